// File: doc/BRIEF.md
# Touch Sample FIFO with Status

This block queues packed touch-panel samples produced by an ADC scan engine and hands them to software through a register-style read port. Each write from the scan engine carries a 10-bit X coordinate, a 10-bit Y coordinate and a pen-level flag. The block packs these into a single 32-bit word and stores it in a small first-in, first-out queue.

Software reads the data port to pop the oldest entry. It can drain the queue by reading until the empty flag in the status word sets. The status word also holds a sticky overrun flag, which records that a sample was lost because the queue was full. A level interrupt tells software when enough samples have accumulated for a full gesture read.

Top module: `touch_sample_fifo`

## Requirements
- R1: A stored word has the Y value in bits 9:0, the X value in bits 25:16 and the pen flag in bit 31. All other bits are 0.
- R2: The pen flag is stored exactly as written: 1 means pen up and 0 means pen down.
- R3: Status bit 7 is 1 exactly when the queue holds no entries.
- R4: `rd_data` always shows the oldest entry. Each `rd_en` cycle on a non-empty queue removes that entry, so entries leave in write order.
- R5: The queue holds DEPTH (4) entries. A write while full and without a read in the same cycle is dropped. A write while full together with a read is accepted.
- R6: Status bit 8 (overrun) sets in the cycle after a dropped write. It stays set until a read leaves the queue empty, or until reset.
- R7: `irq` is 1 exactly while the queue holds at least IRQ_LEVEL (4) entries. It falls in the cycle after a pop that takes the count below that level.
- R8: While the queue is empty, `rd_data` reads 0, and a read neither changes any pointer nor disturbs later entries.
- R9: After reset the queue is empty, overrun is clear, `irq` is 0 and the status word reads 0x00000080.
- R10: All status bits other than 7 and 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Sample write strobe from the scan engine |
| wr_x | input | 10 | X coordinate of the sample |
| wr_y | input | 10 | Y coordinate of the sample |
| wr_pen_up | input | 1 | Pen level: 1 = up, 0 = down |
| rd_en | input | 1 | Data-port read strobe; pops one entry |
| rd_data | output | 32 | Oldest packed entry, or 0 when empty |
| status | output | 32 | Bit 7 empty, bit 8 overrun, others 0 |
| irq | output | 1 | Threshold interrupt level |

## Verification
The hardest situations to reach are at the full boundary. One is a write that coincides with a read on a full queue, which must not count as an overrun. The other is an overrun that must survive partial drains and same-cycle write/read pairs, then clear only on the pop that empties the queue. The vector table fills the queue, forces a drop, and interleaves pops with a combined write/read before the final drain. Directed tests then hit the full-with-read case without a prior overrun, and apply a reset while overrun is set.

// File: rtl/touch_fifo_pkg.sv
package touch_fifo_pkg;
  localparam int TS_WORD_W  = 32;
  localparam int TS_COORD_W = 10;
  localparam int TS_X_LSB   = 16;
  localparam int TS_Y_LSB   = 0;
  localparam int TS_PEN_BIT = 31;
  localparam int TS_EMPTY_BIT = 7;
  localparam int TS_OVR_BIT   = 8;

  function automatic logic [TS_WORD_W-1:0] ts_pack(
    input logic                  pen_up,
    input logic [TS_COORD_W-1:0] x,
    input logic [TS_COORD_W-1:0] y
  );
    logic [TS_WORD_W-1:0] w;
    w = '0;
    w[TS_PEN_BIT] = pen_up;
    w[TS_X_LSB +: TS_COORD_W] = x;
    w[TS_Y_LSB +: TS_COORD_W] = y;
    return w;
  endfunction

  function automatic logic [TS_WORD_W-1:0] ts_status(
    input logic empty,
    input logic overrun
  );
    logic [TS_WORD_W-1:0] s;
    s = '0;
    s[TS_EMPTY_BIT] = empty;
    s[TS_OVR_BIT]   = overrun;
    return s;
  endfunction
endpackage

// File: rtl/tfifo_pack.sv
module tfifo_pack
  import touch_fifo_pkg::*;
(
  input  logic                  pen_up,
  input  logic [TS_COORD_W-1:0] x,
  input  logic [TS_COORD_W-1:0] y,
  output logic [TS_WORD_W-1:0]  word
);
  always_comb word = ts_pack(pen_up, x, y);
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store
  import touch_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TS_WORD_W-1:0] wr_word,
  input  logic                 rd_en,
  output logic [TS_WORD_W-1:0] head_word,
  output logic [CNT_W-1:0]     count,
  output logic                 empty,
  output logic                 push_ok,
  output logic                 push_drop,
  output logic                 pop_ok,
  output logic                 drain_done
);
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [TS_WORD_W-1:0] slot [DEPTH];
  logic full;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign empty      = (count == '0);
  assign full       = (count == CNT_W'(DEPTH));
  assign pop_ok     = rd_en && !empty;
  assign push_ok    = wr_en && (!full || rd_en);
  assign push_drop  = wr_en && full && !rd_en;
  assign drain_done = pop_ok && !push_ok && (count == CNT_W'(1));
  assign head_word  = empty ? '0 : slot[rd_ptr];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          slot[i] <= '0;
        else if (push_ok && (wr_ptr == PTR_W'(i)))
          slot[i] <= wr_word;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tfifo_status.sv
module tfifo_status
  import touch_fifo_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int IRQ_LEVEL = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     count,
  input  logic                 empty,
  input  logic                 push_drop,
  input  logic                 drain_done,
  output logic                 overrun,
  output logic [TS_WORD_W-1:0] status_word,
  output logic                 irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      overrun <= 1'b0;
    else if (push_drop)
      overrun <= 1'b1;
    else if (drain_done)
      overrun <= 1'b0;
  end

  assign status_word = ts_status(empty, overrun);
  assign irq         = (count >= CNT_W'(IRQ_LEVEL));
endmodule

// File: rtl/touch_sample_fifo.sv
module touch_sample_fifo
  import touch_fifo_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int IRQ_LEVEL = 4
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TS_COORD_W-1:0] wr_x,
  input  logic [TS_COORD_W-1:0] wr_y,
  input  logic                  wr_pen_up,
  input  logic                  rd_en,
  output logic [TS_WORD_W-1:0]  rd_data,
  output logic [TS_WORD_W-1:0]  status,
  output logic                  irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TS_WORD_W-1:0] packed_word;
  logic [CNT_W-1:0]     fill_count;
  logic                 q_empty, push_ok, push_drop, pop_ok, drain_done, ovr_flag;

  tfifo_pack u_pack (
    .pen_up (wr_pen_up),
    .x      (wr_x),
    .y      (wr_y),
    .word   (packed_word)
  );

  tfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_word    (packed_word),
    .rd_en      (rd_en),
    .head_word  (rd_data),
    .count      (fill_count),
    .empty      (q_empty),
    .push_ok    (push_ok),
    .push_drop  (push_drop),
    .pop_ok     (pop_ok),
    .drain_done (drain_done)
  );

  tfifo_status #(.DEPTH(DEPTH), .IRQ_LEVEL(IRQ_LEVEL)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (fill_count),
    .empty       (q_empty),
    .push_drop   (push_drop),
    .drain_done  (drain_done),
    .overrun     (ovr_flag),
    .status_word (status),
    .irq         (irq)
  );
endmodule

// File: rtl/tfifo_checker.sv
module tfifo_checker #(
  parameter int DEPTH     = 4,
  parameter int IRQ_LEVEL = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [31:0]      rd_data,
  input logic             empty_bit,
  input logic             ovr_bit,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic             push_drop,
  input logic             drain_done
);
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty_bit |-> (rd_data == 32'h0)); // R8

  AST_EMPTY_READ_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_bit && rd_en && !wr_en) |=> empty_bit); // R8

  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovr_bit); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_bit && !drain_done) |=> ovr_bit); // R6

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_bit) |-> $past(push_drop)); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R5

  AST_IRQ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !empty_bit); // R7

  AST_EMPTY_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    empty_bit == (count == '0)); // R3
endmodule

bind touch_sample_fifo tfifo_checker #(.DEPTH(DEPTH), .IRQ_LEVEL(IRQ_LEVEL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .empty_bit  (status[7]),
  .ovr_bit    (status[8]),
  .irq        (irq),
  .count      (fill_count),
  .push_drop  (push_drop),
  .drain_done (drain_done)
);

// File: tb/tb_touch_sample_fifo.sv
module tb_touch_sample_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, wr_pen_up = 1'b0;
  logic [9:0] wr_x = '0, wr_y = '0;
  logic [31:0] rd_data, status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  touch_sample_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
    .wr_pen_up(wr_pen_up), .rd_en(rd_en), .rd_data(rd_data),
    .status(status), .irq(irq)
  );

  // Layout: [57]wr [56]rd [55]pen [54:45]x [44:35]y [34:3]data before edge
  //         [2]empty [1]overrun [0]irq after edge
  localparam int NV = 13;
  localparam logic [57:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,10'd1,    10'd2,    32'h00000000,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b1,10'd3,    10'd4,    32'h00010002,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b0,10'h3FF,  10'h3FF,  32'h00010002,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b0,10'd5,    10'd6,    32'h00010002,1'b0,1'b0,1'b1},
    {1'b1,1'b0,1'b0,10'd7,    10'd8,    32'h00010002,1'b0,1'b1,1'b1},
    {1'b0,1'b1,1'b0,10'd0,    10'd0,    32'h00010002,1'b0,1'b1,1'b0},
    {1'b0,1'b1,1'b0,10'd0,    10'd0,    32'h80030004,1'b0,1'b1,1'b0},
    {1'b1,1'b1,1'b1,10'd9,    10'd10,   32'h03FF03FF,1'b0,1'b1,1'b0},
    {1'b0,1'b1,1'b0,10'd0,    10'd0,    32'h00050006,1'b0,1'b1,1'b0},
    {1'b0,1'b1,1'b0,10'd0,    10'd0,    32'h8009000A,1'b1,1'b0,1'b0},
    {1'b0,1'b1,1'b0,10'd0,    10'd0,    32'h00000000,1'b1,1'b0,1'b0},
    {1'b1,1'b0,1'b1,10'h155,  10'h2AA,  32'h00000000,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,10'd0,    10'd0,    32'h815502AA,1'b1,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic r, input logic p,
                       input logic [9:0] x, input logic [9:0] y);
    @(negedge clk);
    wr_en = w; rd_en = r; wr_pen_up = p; wr_x = x; wr_y = y;
    #1;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R9 status after reset", status, 32'h00000080);
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);
    chk("R9 rd_data after reset", rd_data, 32'h0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][57], VEC[i][56], VEC[i][55], VEC[i][54:45], VEC[i][44:35]);
      chk($sformatf("R1/R2/R4/R8 data vec %0d", i), rd_data, VEC[i][34:3]);
      settle();
      chk($sformatf("R3/R6/R10 status vec %0d", i), status,
          {23'b0, VEC[i][1], VEC[i][2], 7'b0});
      chk($sformatf("R7 irq vec %0d", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end

    // R5: write together with read on a full queue is accepted, no overrun
    do_reset();
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 1'b0, k[0], 10'(k + 20), 10'(k + 40));
      settle();
    end
    chk("R7 irq at four entries", {31'b0, irq}, 32'h1);
    drive(1'b1, 1'b1, 1'b1, 10'd99, 10'd77);
    chk("R4 head before full write+read", rd_data, 32'h00140028);
    settle();
    chk("R5 full write+read no overrun", status, 32'h00000000);
    chk("R5 count stays full", {31'b0, irq}, 32'h1);
    for (int k = 1; k < 4; k++) begin
      drive(1'b0, 1'b1, 1'b0, 10'd0, 10'd0);
      chk($sformatf("R4 order entry %0d", k), rd_data,
          {k[0], 5'b0, 10'(k + 20), 6'b0, 10'(k + 40)});
      settle();
    end
    drive(1'b0, 1'b1, 1'b0, 10'd0, 10'd0);
    chk("R5 entry written at full kept", rd_data, 32'h8063004D);
    settle();
    chk("R3 empty after drain", status, 32'h00000080);

    // R6: reset clears a set overrun
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 1'b0, 1'b0, 10'd1, 10'd1);
      settle();
    end
    chk("R6 overrun set before reset", status, 32'h00000100);
    do_reset();
    chk("R6 reset clears overrun", status, 32'h00000080);
    chk("R9 irq cleared by reset", {31'b0, irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule